// File: doc/BRIEF.md
# Asynchronous Processor Port for a Time-Slot Switch

This block connects an asynchronous 8-bit microprocessor bus to the storage of a time-slot switch core. The processor marks a cycle by pulling chip select low and raising the data strobe. It sets the direction with a read/write line and picks a location with six address lines. The block brings the strobe into the switch clock domain and carries out the access there. When the access is complete it drives an active-low acknowledge that stays on until the processor ends the cycle.

One address half reaches a local control register. The other half reaches a channel inside a memory bank. The control register picks the bank and the serial stream. There are three banks: two halves of the connection memory, which the bus can read and write, and the data memory, which the bus can only read. The memories are single-ported. The switch core owns every other clock cycle for its serial traffic, and bus accesses only use the cycles in between.

Top module: `cpu_port_tsi`

## Requirements
- R1: An access starts only while chip select is low and strobe is high at the same time. Chip select low with strobe low, or strobe high with chip select high, never produces an acknowledge.
- R2: With address bit 5 at 0, a write stores the 8-bit data in the control register and a read returns its last written value. The register holds 0x00 after reset.
- R3: Control register bits [4:3] select the bank: 00 data memory, 01 connection low, 10 connection high, 11 none. In the none setting, reads return 0x00 and writes change no memory. Bits [2:0] select the stream. With address bit 5 at 1, the memory location is {stream, address[4:0]}.
- R4: A bus write to a connection bank stores the byte at that location. A later bus read of the same location returns it, and it shows on the switch-side output of that bank.
- R5: The data memory takes writes only from the switch side, and a bus read returns what the switch side stored. A bus write aimed at the data memory is still acknowledged but leaves the contents unchanged.
- R6: `sw_slot` alternates every clock between high and low. A bus memory access takes place only in a cycle where `sw_slot` is low. The switch-side address and write are applied at the clock edge that ends a cycle with `sw_slot` high, and the switch-side read data is valid in the cycle after that edge.
- R7: When an access is done, `bus_ack_oe` goes high with `bus_ack_n` low. Both hold while the strobe condition lasts. After the strobe condition ends, the acknowledge is released (`bus_ack_oe` low, `bus_ack_n` high) within 6 clocks.
- R8: `bus_rdata_oe` is high only during a read whose acknowledge is active, and `bus_rdata` then holds the read result. It stays low for writes.
- R9: After reset, `bus_ack_oe` and `bus_rdata_oe` are low and `bus_ack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switch clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_ds | input | 1 | Data strobe, active high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 6 | Bit 5 picks memory (1) or control register (0); bits [4:0] channel |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor |
| bus_rdata_oe | output | 1 | Enable for the read data drivers |
| bus_ack_n | output | 1 | Acknowledge level, low when asserted |
| bus_ack_oe | output | 1 | Acknowledge driver enable (open-drain style) |
| sw_slot | output | 1 | High in cycles owned by the switch side |
| sw_addr | input | 8 | Switch-side memory location {stream, channel} |
| sw_dm_we | input | 1 | Switch-side data memory write |
| sw_dm_wdata | input | 8 | Switch-side data memory write byte |
| sw_dm_q | output | 8 | Data memory read for the switch side |
| sw_cml_q | output | 8 | Connection low read for the switch side |
| sw_cmh_q | output | 8 | Connection high read for the switch side |

## Verification
The bench goes after bank and stream decoding. It fills the same channel in both connection halves with different bytes and reads them back from both sides. A design that swapped the banks, or ignored the stream field, would return the wrong byte. It tests the first and last channel of a stream and the reserved bank setting. If the none setting leaked into a real bank, a later switch-side read would show the changed byte. The bench writes to the data memory from the bus and then reads it back to catch a bus write that was not blocked. It also holds chip select and strobe in their mismatched combinations, where any acknowledge is an error. During writes it watches the read-data enable, which a loose decode would raise.

// File: rtl/tsi_port_pkg.sv
`timescale 1ns/1ps
package tsi_port_pkg;
  typedef enum logic [1:0] {
    BK_DATA    = 2'b00,
    BK_CONN_LO = 2'b01,
    BK_CONN_HI = 2'b10,
    BK_NONE    = 2'b11
  } bank_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CAPT,
    ST_DONE
  } port_state_e;
endpackage

// File: rtl/port_sync.sv
`timescale 1ns/1ps
module port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/port_ram.sv
`timescale 1ns/1ps
module port_ram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/port_fsm.sv
`timescale 1ns/1ps
module port_fsm
  import tsi_port_pkg::*;
#(
  parameter int DW  = 8,
  parameter int SW  = 3,
  parameter int CW  = 5,
  localparam int BAW = CW + 1,
  localparam int MAW = SW + CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic           cpu_slot,
  input  logic [BAW-1:0] bus_addr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  q_dm,
  input  logic [DW-1:0]  q_cl,
  input  logic [DW-1:0]  q_ch,
  output logic [MAW-1:0] cpu_addr,
  output logic [DW-1:0]  cpu_wdata,
  output logic           cpu_go,
  output logic           cpu_we_cl,
  output logic           cpu_we_ch,
  output logic [DW-1:0]  rdata,
  output logic           rdata_oe,
  output logic           ack_n,
  output logic           ack_oe
);
  port_state_e   state, state_n;
  logic [DW-1:0] ctrl;
  logic [CW-1:0] lat_chan;
  logic          lat_rd;
  logic [DW-1:0] lat_wd;
  logic          rd_n;
  bank_e         bank;

  assign bank      = bank_e'(ctrl[SW+1:SW]);
  assign cpu_addr  = {ctrl[SW-1:0], lat_chan};
  assign cpu_wdata = lat_wd;
  assign cpu_go    = (state == ST_WAIT) && cpu_slot;
  assign cpu_we_cl = cpu_go && !lat_rd && (bank == BK_CONN_LO);
  assign cpu_we_ch = cpu_go && !lat_rd && (bank == BK_CONN_HI);
  assign rd_n      = (state == ST_IDLE) ? bus_rd : lat_rd;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (req) state_n = bus_addr[BAW-1] ? ST_WAIT : ST_DONE;
      ST_WAIT: if (cpu_slot) state_n = ST_CAPT;
      ST_CAPT: state_n = ST_DONE;
      ST_DONE: if (!req) state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ctrl     <= '0;
      lat_chan <= '0;
      lat_rd   <= 1'b0;
      lat_wd   <= '0;
      rdata    <= '0;
      rdata_oe <= 1'b0;
      ack_n    <= 1'b1;
      ack_oe   <= 1'b0;
    end else begin
      state    <= state_n;
      ack_oe   <= (state_n == ST_DONE);
      ack_n    <= (state_n != ST_DONE);
      rdata_oe <= (state_n == ST_DONE) && rd_n;
      case (state)
        ST_IDLE: if (req) begin
          lat_chan <= bus_addr[CW-1:0];
          lat_rd   <= bus_rd;
          lat_wd   <= bus_wdata;
          if (!bus_addr[BAW-1]) begin
            if (bus_rd) rdata <= ctrl;
            else        ctrl  <= bus_wdata;
          end
        end
        ST_CAPT: if (lat_rd) begin
          case (bank)
            BK_DATA:    rdata <= q_dm;
            BK_CONN_LO: rdata <= q_cl;
            BK_CONN_HI: rdata <= q_ch;
            default:    rdata <= '0;
          endcase
        end
        default: ;
      endcase
    end
  end

  // R1: no acknowledge rises from an idle port without a request
  p_start_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !req) |=> !ack_oe);
  // R7: acknowledge holds while the request lasts
  p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_oe && req) |=> ack_oe);
  // R7: acknowledge pins agree
  p_ack_pins_r7: assert property (@(posedge clk) disable iff (rst)
    ack_oe |-> !ack_n);
  // R8: data drivers on only for an acknowledged read
  p_oe_read_r8: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> (ack_oe && lat_rd));
endmodule

// File: rtl/cpu_port_tsi.sv
`timescale 1ns/1ps
module cpu_port_tsi #(
  parameter int DW      = 8,
  parameter int STREAMS = 8,
  parameter int CHANS   = 32,
  parameter int SYNC    = 2,
  localparam int SW  = $clog2(STREAMS),
  localparam int CW  = $clog2(CHANS),
  localparam int BAW = CW + 1,
  localparam int MAW = SW + CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_cs_n,
  input  logic           bus_ds,
  input  logic           bus_rd,
  input  logic [BAW-1:0] bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rdata_oe,
  output logic           bus_ack_n,
  output logic           bus_ack_oe,
  output logic           sw_slot,
  input  logic [MAW-1:0] sw_addr,
  input  logic           sw_dm_we,
  input  logic [DW-1:0]  sw_dm_wdata,
  output logic [DW-1:0]  sw_dm_q,
  output logic [DW-1:0]  sw_cml_q,
  output logic [DW-1:0]  sw_cmh_q
);
  localparam int NBANK = 3;

  logic           req_s;
  logic           phase;
  logic           ser_slot;
  logic [MAW-1:0] cpu_addr;
  logic [DW-1:0]  cpu_wdata;
  logic           cpu_go, cpu_we_cl, cpu_we_ch;
  logic [MAW-1:0] r_addr [NBANK];
  logic           r_we   [NBANK];
  logic [DW-1:0]  r_wd   [NBANK];
  logic [DW-1:0]  r_q    [NBANK];

  port_sync #(.STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (!bus_cs_n && bus_ds),
    .q   (req_s)
  );

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= !phase;
  end

  assign ser_slot = !phase;
  assign sw_slot  = ser_slot;

  port_fsm #(.DW(DW), .SW(SW), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (req_s),
    .cpu_slot  (!ser_slot),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .q_dm      (r_q[0]),
    .q_cl      (r_q[1]),
    .q_ch      (r_q[2]),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_go    (cpu_go),
    .cpu_we_cl (cpu_we_cl),
    .cpu_we_ch (cpu_we_ch),
    .rdata     (bus_rdata),
    .rdata_oe  (bus_rdata_oe),
    .ack_n     (bus_ack_n),
    .ack_oe    (bus_ack_oe)
  );

  always_comb begin
    for (int i = 0; i < NBANK; i++) begin
      r_addr[i] = ser_slot ? sw_addr : cpu_addr;
    end
    r_we[0] = ser_slot && sw_dm_we;
    r_we[1] = cpu_we_cl;
    r_we[2] = cpu_we_ch;
    r_wd[0] = sw_dm_wdata;
    r_wd[1] = cpu_wdata;
    r_wd[2] = cpu_wdata;
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    port_ram #(.DW(DW), .AW(MAW)) u_ram (
      .clk   (clk),
      .we    (r_we[g]),
      .addr  (r_addr[g]),
      .wdata (r_wd[g]),
      .q     (r_q[g])
    );
  end

  assign sw_dm_q  = r_q[0];
  assign sw_cml_q = r_q[1];
  assign sw_cmh_q = r_q[2];

  // R6: ownership alternates every cycle
  p_slot_alt_r6: assert property (@(posedge clk) disable iff (rst)
    ser_slot |=> !ser_slot);
  // R6: bus accesses never land in a switch-owned cycle
  p_cpu_slot_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_go |-> !sw_slot);
  // R5: data memory is written only in switch-owned cycles
  p_dm_ro_r5: assert property (@(posedge clk) disable iff (rst)
    r_we[0] |-> sw_slot);
endmodule

// File: tb/test_cpu_port_tsi.sv
`timescale 1ns/1ps
module test_cpu_port_tsi;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_cs_n = 1'b1, bus_ds = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_rdata_oe, bus_ack_n, bus_ack_oe, sw_slot;
  logic [7:0] sw_addr = '0;
  logic       sw_dm_we = 1'b0;
  logic [7:0] sw_dm_wdata = '0;
  logic [7:0] sw_dm_q, sw_cml_q, sw_cmh_q;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_port_tsi i_cpu_port_tsi (
    .clk(clk), .rst(rst), .bus_cs_n(bus_cs_n), .bus_ds(bus_ds), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .bus_ack_n(bus_ack_n), .bus_ack_oe(bus_ack_oe),
    .sw_slot(sw_slot), .sw_addr(sw_addr), .sw_dm_we(sw_dm_we),
    .sw_dm_wdata(sw_dm_wdata), .sw_dm_q(sw_dm_q), .sw_cml_q(sw_cml_q),
    .sw_cmh_q(sw_cmh_q)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: one pop per read data phase
  always @(negedge clk) begin
    if (bus_rdata_oe && !prev_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected read drive", bus_rdata, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata == e, t, bus_rdata, e);
      end
    end
    prev_oe = bus_rdata_oe;
  end

  task automatic bus_xfer(input bit rd, input logic [5:0] a, input logic [7:0] d,
                          input string tag);
    bit seen = 1'b0;
    if (rd) begin exp_q.push_back(d); tag_q.push_back(tag); end
    @(negedge clk);
    bus_cs_n = 1'b0; bus_ds = 1'b1; bus_rd = rd; bus_addr = a; bus_wdata = rd ? 8'h00 : d;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (bus_ack_oe && !bus_ack_n) begin seen = 1'b1; break; end
    end
    chk(seen, "R7 acknowledge given", seen, 1);
    chk(bus_rdata_oe == rd, "R8 data drive matches direction", bus_rdata_oe, rd);
    @(negedge clk);
    chk(bus_ack_oe && !bus_ack_n, "R7 acknowledge held", bus_ack_oe, 1);
    bus_ds = 1'b0; bus_cs_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!bus_ack_oe && bus_ack_n) begin seen = 1'b1; break; end
    end
    chk(seen, "R7 acknowledge released", bus_ack_oe, 0);
    chk(!bus_rdata_oe, "R8 data drive released", bus_rdata_oe, 0);
  endtask

  task automatic ser_write(input logic [7:0] a, input logic [7:0] d);
    do @(negedge clk); while (!sw_slot);
    sw_addr = a; sw_dm_we = 1'b1; sw_dm_wdata = d;
    @(negedge clk);
    sw_dm_we = 1'b0;
  endtask

  task automatic ser_read(input logic [7:0] a, output logic [7:0] dm,
                          output logic [7:0] cl, output logic [7:0] ch);
    do @(negedge clk); while (!sw_slot);
    sw_addr = a;
    @(negedge clk);
    dm = sw_dm_q; cl = sw_cml_q; ch = sw_cmh_q;
  endtask

  task automatic idle_no_ack(input logic cs_n, input logic ds, input string tag);
    bit hit = 1'b0;
    @(negedge clk);
    bus_cs_n = cs_n; bus_ds = ds; bus_rd = 1'b1; bus_addr = 6'h00;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (bus_ack_oe) hit = 1'b1;
    end
    chk(!hit, tag, hit, 0);
    bus_cs_n = 1'b1; bus_ds = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] dm, cl, ch;
    bit alt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!bus_ack_oe && bus_ack_n, "R9 acknowledge idle", bus_ack_oe, 0);
    chk(!bus_rdata_oe, "R9 data drive idle", bus_rdata_oe, 0);
    bus_xfer(1'b1, 6'h00, 8'h00, "R2 reset control value");

    // R1 mismatched strobe combinations
    idle_no_ack(1'b0, 1'b0, "R1 select without strobe");
    idle_no_ack(1'b1, 1'b1, "R1 strobe without select");

    // R2 control register
    bus_xfer(1'b0, 6'h00, 8'hA5, "R2 write");
    bus_xfer(1'b1, 6'h05, 8'hA5, "R2 readback");

    // R6 alternation of ownership
    alt = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      logic prev;
      prev = sw_slot;
      @(negedge clk);
      if (sw_slot == prev) alt = 1'b0;
    end
    chk(alt, "R6 slot alternates", alt, 1);

    // R3/R4 connection banks, stream 3 channel 7
    bus_xfer(1'b0, 6'h00, 8'h0B, "R3 select conn low s3");
    bus_xfer(1'b0, 6'h27, 8'h3C, "R4 write low");
    bus_xfer(1'b0, 6'h00, 8'h13, "R3 select conn high s3");
    bus_xfer(1'b0, 6'h27, 8'hC3, "R4 write high");
    bus_xfer(1'b1, 6'h27, 8'hC3, "R4 read high");
    bus_xfer(1'b0, 6'h00, 8'h0B, "R3 select conn low s3");
    bus_xfer(1'b1, 6'h27, 8'h3C, "R4 read low");
    ser_read(8'h67, dm, cl, ch);
    chk(cl == 8'h3C, "R4 switch side low", cl, 8'h3C);
    chk(ch == 8'hC3, "R4 switch side high", ch, 8'hC3);

    // R3 channel edges of stream 5
    bus_xfer(1'b0, 6'h00, 8'h0D, "R3 select conn low s5");
    bus_xfer(1'b0, 6'h20, 8'h11, "R3 write ch0");
    bus_xfer(1'b0, 6'h3F, 8'hEE, "R3 write ch31");
    bus_xfer(1'b1, 6'h20, 8'h11, "R3 read ch0");
    bus_xfer(1'b1, 6'h3F, 8'hEE, "R3 read ch31");
    ser_read(8'hA0, dm, cl, ch);
    chk(cl == 8'h11, "R3 switch side s5 ch0", cl, 8'h11);
    ser_read(8'hBF, dm, cl, ch);
    chk(cl == 8'hEE, "R3 switch side s5 ch31", cl, 8'hEE);

    // R5 data memory read-only from the bus
    ser_write(8'h42, 8'h77);
    bus_xfer(1'b0, 6'h00, 8'h02, "R3 select data s2");
    bus_xfer(1'b1, 6'h22, 8'h77, "R5 read switch byte");
    bus_xfer(1'b0, 6'h22, 8'h00, "R5 write ignored");
    bus_xfer(1'b1, 6'h22, 8'h77, "R5 contents kept");
    ser_read(8'h42, dm, cl, ch);
    chk(dm == 8'h77, "R5 switch side kept", dm, 8'h77);

    // R3 reserved bank
    bus_xfer(1'b0, 6'h00, 8'h1B, "R3 select none s3");
    bus_xfer(1'b0, 6'h27, 8'h99, "R3 write to none");
    bus_xfer(1'b1, 6'h27, 8'h00, "R3 none reads zero");
    ser_read(8'h67, dm, cl, ch);
    chk(cl == 8'h3C, "R3 none left low intact", cl, 8'h3C);
    chk(ch == 8'hC3, "R3 none left high intact", ch, 8'hC3);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads driven", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule